// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external serial master read and write a small bank of 16-bit configuration registers. The master pulls the active-low select line down, clocks a 24-bit frame in on the serial clock, and releases select. The frame holds a one-bit command flag, a spare bit, a 6-bit register address and a 16-bit data word. All serial inputs are brought into the block's own clock domain, and edges are detected there. The serial clock must therefore be several times slower than the system clock.

A read is answered in the following access cycle. While the master shifts in its next frame, the block shifts out the header of the previous complete frame, followed by the word read from the addressed register. Register 3 controls the serial output. One bit in it enables the output driver. A second bit selects whether output bits advance on falling or on rising serial clock edges. The full register bank is presented in parallel to downstream logic.

Top module: `spi_regif`

## Requirements
- R1: An access cycle runs from the falling edge of `sel_n` to its rising edge. While `sel_n` is low, `sdi` is sampled on each falling edge of `sclk`, most significant bit first.
- R2: A frame is decoded as follows. Bit 23 is the command (0 = write, 1 = read). Bit 22 is ignored. Bits 21:16 are the address. Bits 15:0 are the data word. The data word of a read changes no register.
- R3: A write carried in a complete frame updates the addressed register, and `regs_o`, within a few system clocks after `sel_n` rises. Register k occupies `regs_o[16k+15:16k]`.
- R4: A cycle with fewer than 24 falling `sclk` edges changes no register. It also leaves the pending-read state and the echoed header unchanged.
- R5: Bits after the 24th in one access cycle are ignored.
- R6: Toggling `sclk` and `sdi` while `sel_n` is high has no effect.
- R7: A write to an address at or above NUM_REGS (default 8) changes nothing. A read of such an address returns zero data.
- R8: The output frame of each access cycle is built from the previous complete frame. Bits 23:16 repeat that frame's bits 23:16. Bits 15:0 hold the addressed register's value if that frame was a read, and zero otherwise.
- R9: `sdo_drive` is high, and `sdo` is driven, only while `sel_n` is low and bit 5 of register 3 is set. At all other times `sdo` is high-impedance.
- R10: Bit 23 of the output frame appears when select falls. Each output edge then advances one bit, and after 24 advances `sdo` is 0. Bit 4 of register 3 picks the output edge: 0 means falling `sclk` edges, 1 means rising edges.
- R11: After reset, every register is zero, the echoed header is zero and no read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low access select |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Tri-state serial data out |
| sdo_drive | output | 1 | High while `sdo` is driven (pad enable) |
| regs_o | output | NUM_REGS*16 | All registers, concatenated, register 0 lowest |

## Verification
The bench covers several frame patterns:
- Full writes with the spare bit both clear and set. These separate address and data decoding from the ignored bit.
- Read frames followed by a write, which exposes the deferred echo and its data.
- Truncated frames and over-long frames, which separate the 24-bit acceptance rule from plain bit counting.
- Unmapped addresses, and clock and data activity while select is high.

Every output bit is compared on both serial edges in falling-edge mode and in rising-edge mode, and with the output disabled. This catches an off-by-one edge, a wrong edge choice or an output enable that is not gated.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;
  localparam int FRAME_W      = 24;
  localparam int ADDR_W       = 6;
  localparam int DATA_W       = 16;
  localparam int HDR_W        = FRAME_W - DATA_W;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 6'h03;
  localparam int CFG_OE_BIT   = 5;
  localparam int CFG_EDGE_BIT = 4;

  typedef struct packed {
    logic              rd;
    logic              spare;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/spi_regif_edges.sv
module spi_regif_edges #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic active_o,
  output logic sel_fall_o,
  output logic sel_rise_o,
  output logic sck_fall_o,
  output logic sck_rise_o,
  output logic sdi_o
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE = 3'b001;

  logic [W-1:0] stage [STAGES];
  logic [W-1:0] last;
  logic [W-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= IDLE;
      last <= IDLE;
    end else begin
      stage[0] <= {sdi_i, sclk_i, sel_n_i};
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
      last <= stage[STAGES-1];
    end
  end

  assign cur        = stage[STAGES-1];
  assign active_o   = ~cur[0];
  assign sel_fall_o = last[0] & ~cur[0];
  assign sel_rise_o = ~last[0] & cur[0];
  assign sck_fall_o = ~cur[0] & last[1] & ~cur[1];
  assign sck_rise_o = ~cur[0] & ~last[1] & cur[1];
  assign sdi_o      = cur[2];
endmodule

// File: rtl/spi_regif_rx.sv
module spi_regif_rx
  import spi_regif_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   active,
  input  logic   sel_fall,
  input  logic   sel_rise,
  input  logic   sck_fall,
  input  logic   sdi,
  output logic   valid_o,
  output frame_t frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               full;

  assign full = (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      cnt     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= sel_rise & full;
      if (sel_fall) begin
        cnt <= '0;
      end else if (sck_fall && !full) begin
        shreg <= {shreg[FRAME_W-2:0], sdi};
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assign frame_o = frame_t'(shreg);

  a_r5_count_cap: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_W));

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(shreg));
endmodule

// File: rtl/spi_regif_bank.sv
module spi_regif_bank
  import spi_regif_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       cfg_oe_o,
  output logic                       cfg_edge_o
);
  localparam int IDX_W   = $clog2(NUM_REGS);
  localparam int CFG_IDX = int'(CFG_ADDR);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic wr_hit, rd_hit;

  assign wr_hit = wr_en && (wr_addr < ADDR_W'(NUM_REGS));
  assign rd_hit = (rd_addr < ADDR_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (wr_hit) begin
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? mem[rd_addr[IDX_W-1:0]] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_o[g*DATA_W +: DATA_W] = mem[g];
  end

  assign cfg_oe_o   = mem[CFG_IDX][CFG_OE_BIT];
  assign cfg_edge_o = mem[CFG_IDX][CFG_EDGE_BIT];

  a_r7_unmapped_no_write: assert property (@(posedge clk) disable iff (rst)
    wr_en && !(wr_addr < ADDR_W'(NUM_REGS)) |=> $stable(regs_o));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> mem[$past(wr_addr[IDX_W-1:0])] == $past(wr_data));

  a_r11_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (regs_o == '0));
endmodule

// File: rtl/spi_regif_tx.sv
module spi_regif_tx
  import spi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              sel_fall,
  input  logic              sck_fall,
  input  logic              sck_rise,
  input  logic              frame_valid,
  input  frame_t            frame_i,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              cfg_oe,
  input  logic              cfg_edge,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sdo_bit_o,
  output logic              sdo_drive_o
);
  logic [HDR_W-1:0]   hdr_q;
  logic               pend_q;
  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] fbits;
  logic               adv;

  assign fbits   = frame_i;
  assign rd_addr = hdr_q[ADDR_W-1:0];
  assign adv     = cfg_edge ? sck_rise : sck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q       <= '0;
      pend_q      <= 1'b0;
      shreg       <= '0;
      sdo_drive_o <= 1'b0;
    end else begin
      if (frame_valid) begin
        hdr_q  <= fbits[FRAME_W-1 -: HDR_W];
        pend_q <= frame_i.rd;
      end
      if (sel_fall) begin
        shreg <= {hdr_q, (pend_q ? rd_data : {DATA_W{1'b0}})};
      end else if (adv) begin
        shreg <= {shreg[FRAME_W-2:0], 1'b0};
      end
      sdo_drive_o <= active & cfg_oe;
    end
  end

  assign sdo_bit_o = shreg[FRAME_W-1];

  a_r10_quiet_between_edges: assert property (@(posedge clk) disable iff (rst)
    !sel_fall && !sck_fall && !sck_rise |=> $stable(shreg));

  a_r8_zero_data_no_pend: assert property (@(posedge clk) disable iff (rst)
    sel_fall && !pend_q |=> shreg[DATA_W-1:0] == '0);

  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !active |=> !sdo_drive_o);
endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sel_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  output logic                       sdo_drive,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  logic active, sel_fall, sel_rise, sck_fall, sck_rise, sdi_s;
  logic rx_valid;
  frame_t rx_frame;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic cfg_oe, cfg_edge, sdo_bit;

  spi_regif_edges #(.STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .active_o(active), .sel_fall_o(sel_fall), .sel_rise_o(sel_rise),
    .sck_fall_o(sck_fall), .sck_rise_o(sck_rise), .sdi_o(sdi_s)
  );

  spi_regif_rx u_rx (
    .clk(clk), .rst(rst), .active(active), .sel_fall(sel_fall),
    .sel_rise(sel_rise), .sck_fall(sck_fall), .sdi(sdi_s),
    .valid_o(rx_valid), .frame_o(rx_frame)
  );

  spi_regif_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .wr_en(rx_valid & ~rx_frame.rd),
    .wr_addr(rx_frame.addr), .wr_data(rx_frame.data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_o(regs_o),
    .cfg_oe_o(cfg_oe), .cfg_edge_o(cfg_edge)
  );

  spi_regif_tx u_tx (
    .clk(clk), .rst(rst), .active(active), .sel_fall(sel_fall),
    .sck_fall(sck_fall), .sck_rise(sck_rise), .frame_valid(rx_valid),
    .frame_i(rx_frame), .rd_data(rd_data), .cfg_oe(cfg_oe),
    .cfg_edge(cfg_edge), .rd_addr(rd_addr), .sdo_bit_o(sdo_bit),
    .sdo_drive_o(sdo_drive)
  );

  assign sdo = sdo_drive ? sdo_bit : 1'bz;
endmodule

// File: tb/spi_regif_bench.sv
module spi_regif_bench;
  localparam int NR   = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  wire  sdo;
  logic sdo_drive;
  logic [NR*16-1:0] regs_o;

  int total = 0;
  int fails = 0;
  bit settle = 1'b1;
  bit done = 1'b0;

  logic [15:0] m_reg [NR];
  logic [7:0]  m_hdr;
  bit          m_pend;

  always #5 clk = ~clk;

  spi_regif u_spi_regif (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_drive(sdo_drive), .regs_o(regs_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mread(input logic [5:0] a);
    return (a < 6'(NR)) ? m_reg[a[2:0]] : 16'h0;
  endfunction

  function automatic logic [31:0] wf(input bit rd, input bit sp, input logic [5:0] a, input logic [15:0] d);
    return {8'h00, rd, sp, a, d};
  endfunction

  // reference comparison of the register outputs on every clock (R3)
  always @(negedge clk) begin
    if (!rst && !settle && !done) begin
      for (int g = 0; g < NR; g++)
        chk(regs_o[g*16 +: 16] == m_reg[g], "R3 regs_o", 32'(regs_o[g*16 +: 16]), 32'(m_reg[g]));
    end
  end

  task automatic chk_sdo(input bit oe, input logic [23:0] resp, input int idx, input string tag);
    logic eb;
    eb = (idx < 24) ? resp[23-idx] : 1'b0;
    if (oe) chk(sdo_drive === 1'b1 && sdo === eb, tag, {30'h0, sdo_drive, sdo}, {30'h0, 1'b1, eb});
    else    chk(sdo_drive === 1'b0, {tag, " R9 disabled"}, 32'(sdo_drive), 32'h0);
  endtask

  task automatic frame(input logic [31:0] bits, input int nbits, input string tag);
    logic [23:0] resp;
    logic [31:0] f;
    bit oe, edg;
    int rises = 0;
    int falls = 0;
    resp = {m_hdr, (m_pend ? mread(m_hdr[5:0]) : 16'h0)};
    oe   = m_reg[3][5];
    edg  = m_reg[3][4];
    sel_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = bits[nbits-1-i];
      chk_sdo(oe, resp, edg ? rises : falls, {tag, " R8/R10 sdo"});
      sclk = 1'b1; rises++;
      tick(HALF);
      chk_sdo(oe, resp, edg ? rises : falls, {tag, " R8/R10 sdo"});
      sclk = 1'b0; falls++;
      tick(HALF);
    end
    settle = 1'b1;
    sel_n = 1'b1;
    tick(8);
    if (nbits >= 24) begin
      f = bits >> (nbits - 24);
      if (!f[23] && f[21:16] < 6'(NR)) m_reg[f[18:16]] = f[15:0];
      m_hdr  = f[23:16];
      m_pend = f[23];
    end
    settle = 1'b0;
    chk(sdo_drive === 1'b0, {tag, " R9 idle release"}, 32'(sdo_drive), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) m_reg[i] = 16'h0;
    m_hdr = 8'h00; m_pend = 1'b0;
    tick(10);
    rst = 1'b0;
    tick(2);
    chk(regs_o == '0, "R11 reset regs", 32'(regs_o[31:0]), 32'h0);
    chk(sdo_drive === 1'b0, "R11 reset sdo released", 32'(sdo_drive), 32'h0);
    settle = 1'b0;

    // output disabled after reset: echo is zero but not driven (R9, R11)
    frame(wf(0, 0, 6'h03, 16'h0020), 24, "R1 cfg enable");
    chk(regs_o[3*16 +: 16] == 16'h0020, "R1 cfg written", 32'(regs_o[3*16 +: 16]), 32'h20);
    frame(wf(0, 0, 6'h01, 16'hA5C3), 24, "R3 write r1");
    chk(regs_o[16 +: 16] == 16'hA5C3, "R1 MSB-first r1", 32'(regs_o[16 +: 16]), 32'hA5C3);
    frame(wf(0, 1, 6'h02, 16'h1234), 24, "R2 spare set");
    chk(regs_o[32 +: 16] == 16'h1234, "R2 spare ignored", 32'(regs_o[32 +: 16]), 32'h1234);
    frame(wf(1, 0, 6'h01, 16'hFFFF), 24, "R2 read r1");
    chk(regs_o[16 +: 16] == 16'hA5C3, "R2 read data no effect", 32'(regs_o[16 +: 16]), 32'hA5C3);
    frame(wf(0, 0, 6'h06, 16'h0F0F), 24, "R8 echo of read");
    // short frame: no write and header unchanged
    frame(wf(0, 0, 6'h01, 16'h0000) >> 4, 20, "R4 short");
    chk(regs_o[16 +: 16] == 16'hA5C3, "R4 short dropped", 32'(regs_o[16 +: 16]), 32'hA5C3);
    frame(wf(1, 1, 6'h02, 16'h0000), 24, "R4 echo after short");
    frame({wf(0, 0, 6'h05, 16'hBEEF)[23:0], 6'b101101}, 30, "R5 long");
    chk(regs_o[5*16 +: 16] == 16'hBEEF, "R5 extra bits ignored", 32'(regs_o[5*16 +: 16]), 32'hBEEF);
    frame(wf(0, 0, 6'h2A, 16'h7777), 24, "R7 unmapped write");
    frame(wf(1, 0, 6'h2A, 16'h0000), 24, "R7 unmapped read");
    frame(wf(0, 0, 6'h00, 16'h0001), 24, "R7 unmapped echo zero");
    // rising-edge output mode
    frame(wf(0, 0, 6'h03, 16'h0030), 24, "R10 set rising");
    frame(wf(1, 0, 6'h05, 16'h0000), 24, "R10 read r5");
    frame(wf(1, 0, 6'h03, 16'h0000), 24, "R10 rising echo");
    frame(wf(0, 0, 6'h07, 16'hC001), 24, "R10 rising cfg echo");
    // idle activity while select high (R6)
    for (int k = 0; k < 30; k++) begin
      sdi = k[0] ^ k[2];
      sclk = ~sclk;
      tick(HALF);
    end
    sclk = 1'b0;
    tick(HALF);
    chk(regs_o[7*16 +: 16] == 16'hC001, "R6 idle toggles ignored", 32'(regs_o[7*16 +: 16]), 32'hC001);
    frame(wf(0, 0, 6'h03, 16'h0000), 24, "R6 echo after idle");
    // output disabled: never driven during a frame (R9)
    frame(wf(1, 0, 6'h07, 16'h0000), 24, "R9 disabled read");
    chk(regs_o[3*16 +: 16] == 16'h0000, "R9 cfg cleared", 32'(regs_o[3*16 +: 16]), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule